// File: doc/BRIEF.md
# Serial port register decoder

This block is the bus-facing register decoder of a serial port. It occupies a 4 KB address window on an APB-style slave interface with no wait states. It holds the configuration registers: baud divisors, line and port control, FIFO trigger level, interrupt mask, DMA control and the infrared low-power divisor. It also forwards reads and writes to the receive buffer, transmit buffer and interrupt logic. Those three sit outside the block and are reached through one-cycle strobes.

A read of the data register returns the word at the head of the receive buffer. The same access pops that word and latches its four error bits into a receive-status register, which software can read afterwards. The flag, raw-status and masked-status registers are read-only. The clear register is write-only. The top eight words of the window return fixed identification bytes. Any offset the block does not decode reads as zero and ignores writes.

Top module: `uart_reg_if`

## Requirements
- R1: Byte offsets decode as follows. Data 0x000, receive status 0x004, flags 0x018, infrared divisor 0x020, integer divisor 0x024, fractional divisor 0x028, line control 0x02C, port control 0x030, FIFO level 0x034, mask 0x038, raw status 0x03C, masked status 0x040, clear 0x044, DMA control 0x048.
- R2: After reset the FIFO-level register reads 0x12. The integer and fractional divisors, infrared divisor, DMA control, mask, line control, port control and receive status all read 0, and break_o is 0.
- R3: The integer divisor keeps the low 16 bits of a write and the fractional divisor keeps the low 6 bits. The other registers keep these low bits: infrared divisor 8, line control 8, port control 16, FIFO level 6, mask 11, DMA control 3.
- R4: A data read returns rx_data_i zero-extended. rx_pop_o is high only during the access phase of that read, never in its setup phase and never on a data write.
- R5: A data read copies rx_data_i[11:8] into receive-status bits 3:0.
- R6: Any write to the receive-status register clears it to 0.
- R7: Writes to the flag, raw-status and masked-status registers have no effect. These registers read flags_i, irq_raw_i and irq_raw_i AND mask respectively.
- R8: A data write raises tx_push_o for its access phase, with tx_data_o equal to pwdata_i[7:0].
- R9: A clear write raises irq_clr_o for its access phase, with irq_clr_mask_o equal to pwdata_i[10:0]. The clear register reads 0.
- R10: Word offsets 0xFE0 to 0xFFC read one identification byte each, in this order: 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Undecoded offsets, and any address with bits 1:0 not zero, read 0 and discard writes.
- R12: break_o equals line-control bit 0 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | Write when high |
| paddr_i | input | 12 | Byte address within window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid in access phase |
| rx_data_i | input | 12 | Head of receive buffer: 8 data bits, 4 error bits |
| rx_pop_o | output | 1 | Pop receive buffer |
| tx_push_o | output | 1 | Push transmit buffer |
| tx_data_o | output | 8 | Byte to transmit |
| flags_i | input | 9 | Live flag bits from the buffers and modem lines |
| irq_raw_i | input | 11 | Raw interrupt status |
| irq_clr_o | output | 1 | Clear strobe to interrupt logic |
| irq_clr_mask_o | output | 11 | Bits to clear |
| irq_mask_o | output | 11 | Interrupt enable mask |
| baud_int_o | output | 16 | Integer baud divisor |
| baud_frac_o | output | 6 | Fractional baud divisor |
| line_ctrl_o | output | 8 | Line control |
| port_ctrl_o | output | 16 | Port control |
| fifo_lvl_o | output | 6 | FIFO trigger level select |
| dma_ctrl_o | output | 3 | DMA control |
| irda_div_o | output | 8 | Infrared low-power divisor |
| break_o | output | 1 | Send break |

## Verification
The hardest case to reach is the pop side effect, because the pop must appear in one phase of the transfer and not in the other. The bench therefore samples rx_pop_o separately in the setup and access phases of each transfer. It also holds a character with non-zero error bits on rx_data_i, so that the later receive-status read shows whether the latch came from the popped word. Misaligned writes aimed at a live register are followed by a read of that register, to show that they were discarded.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int NREG = 14;
  localparam int R_DATA = 0, R_RXST = 1, R_FLAG = 2, R_IRDA = 3, R_IDIV = 4,
                 R_FDIV = 5, R_LINE = 6, R_CTRL = 7, R_FLVL = 8, R_MASK = 9,
                 R_RAW = 10, R_MSKD = 11, R_CLR = 12, R_DMA = 13;

  localparam int IRDA_W = 8, IDIV_W = 16, FDIV_W = 6, LINE_W = 8, CTRL_W = 16;
  localparam int FLVL_W = 6, INT_W = 11, DMA_W = 3, RXD_W = 12, ERR_W = 4, FLAG_W = 9;
  localparam int WD_W = 16;
  localparam logic [FLVL_W-1:0] FLVL_RST = 6'h12;

  typedef struct packed {
    logic [IRDA_W-1:0] irda;
    logic [IDIV_W-1:0] idiv;
    logic [FDIV_W-1:0] fdiv;
    logic [LINE_W-1:0] line;
    logic [CTRL_W-1:0] ctrl;
    logic [FLVL_W-1:0] flvl;
    logic [INT_W-1:0]  mask;
    logic [DMA_W-1:0]  dma;
  } cfg_t;

  function automatic logic [11:0] reg_offset(input int idx);
    case (idx)
      R_DATA: return 12'h000;
      R_RXST: return 12'h004;
      R_FLAG: return 12'h018;
      R_IRDA: return 12'h020;
      R_IDIV: return 12'h024;
      R_FDIV: return 12'h028;
      R_LINE: return 12'h02C;
      R_CTRL: return 12'h030;
      R_FLVL: return 12'h034;
      R_MASK: return 12'h038;
      R_RAW:  return 12'h03C;
      R_MSKD: return 12'h040;
      R_CLR:  return 12'h044;
      default: return 12'h048;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: return 8'h11;
      3'd1: return 8'h10;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o,
  output logic              id_hit_o,
  output logic [2:0]        id_idx_o
);
  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    localparam logic [11:0] OFS = reg_offset(g);
    assign sel_o[g] = aligned && (addr_i[ADDR_W-1:2] == OFS[ADDR_W-1:2]);
  end

  // identification bytes live in the last eight words
  assign id_hit_o = aligned && (addr_i[ADDR_W-1:5] == '1);
  assign id_idx_o = addr_i[4:2];
endmodule

// File: rtl/uart_reg_file.sv
module uart_reg_file
  import uart_reg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] wr_sel_i,
  input  logic [WD_W-1:0] wdata_i,
  input  logic            pop_i,
  input  logic [ERR_W-1:0] rx_err_i,
  output cfg_t            cfg_o,
  output logic [ERR_W-1:0] rx_stat_o
);
  cfg_t cfg_q;
  logic [ERR_W-1:0] rx_stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      cfg_q.flvl <= FLVL_RST;
    end else begin
      if (wr_sel_i[R_IRDA]) cfg_q.irda <= wdata_i[IRDA_W-1:0];
      if (wr_sel_i[R_IDIV]) cfg_q.idiv <= wdata_i[IDIV_W-1:0];
      if (wr_sel_i[R_FDIV]) cfg_q.fdiv <= wdata_i[FDIV_W-1:0];
      if (wr_sel_i[R_LINE]) cfg_q.line <= wdata_i[LINE_W-1:0];
      if (wr_sel_i[R_CTRL]) cfg_q.ctrl <= wdata_i[CTRL_W-1:0];
      if (wr_sel_i[R_FLVL]) cfg_q.flvl <= wdata_i[FLVL_W-1:0];
      if (wr_sel_i[R_MASK]) cfg_q.mask <= wdata_i[INT_W-1:0];
      if (wr_sel_i[R_DMA])  cfg_q.dma  <= wdata_i[DMA_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rx_stat_q <= '0;
    else if (pop_i)           rx_stat_q <= rx_err_i;
    else if (wr_sel_i[R_RXST]) rx_stat_q <= '0;
  end

  assign cfg_o     = cfg_q;
  assign rx_stat_o = rx_stat_q;

  a_r5_status_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> rx_stat_q == $past(rx_err_i));
  a_r6_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i[R_RXST] && !pop_i) |=> rx_stat_q == '0);
  a_r7_flag_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i[R_FLAG] || wr_sel_i[R_RAW] || wr_sel_i[R_MSKD]) |=> $stable(cfg_q));
endmodule

// File: rtl/uart_reg_rdmux.sv
module uart_reg_rdmux
  import uart_reg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              rd_en_i,
  input  logic [NREG-1:0]   sel_i,
  input  logic              id_hit_i,
  input  logic [2:0]        id_idx_i,
  input  cfg_t              cfg_i,
  input  logic [ERR_W-1:0]  rx_stat_i,
  input  logic [RXD_W-1:0]  rx_data_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [INT_W-1:0]  raw_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (id_hit_i)     rdata_o = DATA_W'(id_byte(id_idx_i));
      if (sel_i[R_DATA]) rdata_o = DATA_W'(rx_data_i);
      if (sel_i[R_RXST]) rdata_o = DATA_W'(rx_stat_i);
      if (sel_i[R_FLAG]) rdata_o = DATA_W'(flags_i);
      if (sel_i[R_IRDA]) rdata_o = DATA_W'(cfg_i.irda);
      if (sel_i[R_IDIV]) rdata_o = DATA_W'(cfg_i.idiv);
      if (sel_i[R_FDIV]) rdata_o = DATA_W'(cfg_i.fdiv);
      if (sel_i[R_LINE]) rdata_o = DATA_W'(cfg_i.line);
      if (sel_i[R_CTRL]) rdata_o = DATA_W'(cfg_i.ctrl);
      if (sel_i[R_FLVL]) rdata_o = DATA_W'(cfg_i.flvl);
      if (sel_i[R_MASK]) rdata_o = DATA_W'(cfg_i.mask);
      if (sel_i[R_RAW])  rdata_o = DATA_W'(raw_i);
      if (sel_i[R_MSKD]) rdata_o = DATA_W'(raw_i & cfg_i.mask);
      if (sel_i[R_DMA])  rdata_o = DATA_W'(cfg_i.dma);
    end
  end
endmodule

// File: rtl/uart_reg_if.sv
module uart_reg_if
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic [RXD_W-1:0]  rx_data_i,
  output logic              rx_pop_o,
  output logic              tx_push_o,
  output logic [7:0]        tx_data_o,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [INT_W-1:0]  irq_raw_i,
  output logic              irq_clr_o,
  output logic [INT_W-1:0]  irq_clr_mask_o,
  output logic [INT_W-1:0]  irq_mask_o,
  output logic [IDIV_W-1:0] baud_int_o,
  output logic [FDIV_W-1:0] baud_frac_o,
  output logic [LINE_W-1:0] line_ctrl_o,
  output logic [CTRL_W-1:0] port_ctrl_o,
  output logic [FLVL_W-1:0] fifo_lvl_o,
  output logic [DMA_W-1:0]  dma_ctrl_o,
  output logic [IRDA_W-1:0] irda_div_o,
  output logic              break_o
);
  logic [NREG-1:0] sel, wr_sel;
  logic id_hit, acc, wr_acc, rd_acc;
  logic [2:0] id_idx;
  logic [ERR_W-1:0] rx_stat;
  cfg_t cfg;

  assign acc    = psel_i & penable_i;
  assign wr_acc = acc & pwrite_i;
  assign rd_acc = acc & ~pwrite_i;
  assign wr_sel = sel & {NREG{wr_acc}};

  uart_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(paddr_i), .sel_o(sel), .id_hit_o(id_hit), .id_idx_o(id_idx)
  );

  uart_reg_file u_regs (
    .clk_i, .rst_ni, .wr_sel_i(wr_sel), .wdata_i(pwdata_i[WD_W-1:0]),
    .pop_i(rx_pop_o), .rx_err_i(rx_data_i[RXD_W-1 -: ERR_W]),
    .cfg_o(cfg), .rx_stat_o(rx_stat)
  );

  uart_reg_rdmux #(.DATA_W(DATA_W)) u_rd (
    .rd_en_i(rd_acc), .sel_i(sel), .id_hit_i(id_hit), .id_idx_i(id_idx),
    .cfg_i(cfg), .rx_stat_i(rx_stat), .rx_data_i, .flags_i, .raw_i(irq_raw_i),
    .rdata_o(prdata_o)
  );

  assign rx_pop_o       = rd_acc & sel[R_DATA];
  assign tx_push_o      = wr_acc & sel[R_DATA];
  assign tx_data_o      = pwdata_i[7:0];
  assign irq_clr_o      = wr_acc & sel[R_CLR];
  assign irq_clr_mask_o = pwdata_i[INT_W-1:0];

  assign irq_mask_o  = cfg.mask;
  assign baud_int_o  = cfg.idiv;
  assign baud_frac_o = cfg.fdiv;
  assign line_ctrl_o = cfg.line;
  assign port_ctrl_o = cfg.ctrl;
  assign fifo_lvl_o  = cfg.flvl;
  assign dma_ctrl_o  = cfg.dma;
  assign irda_div_o  = cfg.irda;
  assign break_o     = cfg.line[0];

  a_r1_decode_unique: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel, id_hit}));
  a_r4_pop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |=> !rx_pop_o);
  a_r12_break_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && sel[R_LINE]) |=> break_o == $past(pwdata_i[0]));
  a_r9_clear_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |=> !irq_clr_o);
endmodule

// File: tb/tb_uart_reg_if.sv
module tb_uart_reg_if;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, pen = 0, pwr = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [11:0] rx_data = 12'h000;
  logic [8:0]  flags = 9'h1A5;
  logic [10:0] raw = 11'h3C3;
  logic rx_pop, tx_push, irq_clr, brk;
  logic [7:0] tx_data, irda_o, line_o;
  logic [10:0] clr_mask, mask_o;
  logic [15:0] bint_o, ctrl_o;
  logic [5:0] bfrac_o, flvl_o;
  logic [2:0] dma_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_reg_if dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(pen), .pwrite_i(pwr),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .rx_data_i(rx_data),
    .rx_pop_o(rx_pop), .tx_push_o(tx_push), .tx_data_o(tx_data), .flags_i(flags),
    .irq_raw_i(raw), .irq_clr_o(irq_clr), .irq_clr_mask_o(clr_mask),
    .irq_mask_o(mask_o), .baud_int_o(bint_o), .baud_frac_o(bfrac_o),
    .line_ctrl_o(line_o), .port_ctrl_o(ctrl_o), .fifo_lvl_o(flvl_o),
    .dma_ctrl_o(dma_o), .irda_div_o(irda_o), .break_o(brk)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd3,  12'h024, 32'hFFFF_ABCD, 32'h0},     // R3
    '{1'b0, 4'd3,  12'h024, 32'h0, 32'h0000_ABCD},
    '{1'b1, 4'd3,  12'h028, 32'h0000_00FF, 32'h0},
    '{1'b0, 4'd3,  12'h028, 32'h0, 32'h0000_003F},
    '{1'b1, 4'd3,  12'h02C, 32'h0000_01F6, 32'h0},
    '{1'b0, 4'd3,  12'h02C, 32'h0, 32'h0000_00F6},
    '{1'b1, 4'd3,  12'h030, 32'h0001_2345, 32'h0},
    '{1'b0, 4'd3,  12'h030, 32'h0, 32'h0000_2345},
    '{1'b1, 4'd3,  12'h034, 32'h0000_00ED, 32'h0},
    '{1'b0, 4'd3,  12'h034, 32'h0, 32'h0000_002D},
    '{1'b1, 4'd3,  12'h038, 32'h0000_FFFF, 32'h0},
    '{1'b0, 4'd3,  12'h038, 32'h0, 32'h0000_07FF},
    '{1'b1, 4'd3,  12'h048, 32'h0000_00FF, 32'h0},
    '{1'b0, 4'd3,  12'h048, 32'h0, 32'h0000_0007},
    '{1'b1, 4'd3,  12'h020, 32'h0000_03A5, 32'h0},
    '{1'b0, 4'd3,  12'h020, 32'h0, 32'h0000_00A5},
    '{1'b1, 4'd7,  12'h018, 32'h0000_0055, 32'h0},     // R7
    '{1'b0, 4'd7,  12'h018, 32'h0, 32'h0000_01A5},
    '{1'b1, 4'd7,  12'h03C, 32'h0000_0000, 32'h0},
    '{1'b0, 4'd7,  12'h03C, 32'h0, 32'h0000_03C3},
    '{1'b0, 4'd7,  12'h040, 32'h0, 32'h0000_03C3},
    '{1'b0, 4'd9,  12'h044, 32'h0, 32'h0},             // R9
    '{1'b0, 4'd11, 12'h04C, 32'h0, 32'h0},             // R11
    '{1'b1, 4'd11, 12'h025, 32'h0000_1111, 32'h0},
    '{1'b0, 4'd11, 12'h024, 32'h0, 32'h0000_ABCD},
    '{1'b0, 4'd11, 12'h026, 32'h0, 32'h0}
  };

  logic [7:0] id_exp [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // setup then access phase; strobes sampled in each phase before the edge
  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic pop_s, output logic pop_a,
                      output logic push_a, output logic clr_a);
    @(negedge clk);
    psel = 1; pen = 0; pwr = wr; paddr = a; pwdata = d;
    #1 pop_s = rx_pop;
    @(negedge clk);
    pen = 1;
    #1 begin rd = prdata; pop_a = rx_pop; push_a = tx_push; clr_a = irq_clr; end
    @(negedge clk);
    psel = 0; pen = 0; pwr = 0;
  endtask

  initial begin
    logic [31:0] rd;
    logic ps, pa, pu, cl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset values
    xfer(0, 12'h034, 0, rd, ps, pa, pu, cl); chk(2, "flvl rst", rd, 32'h12);
    xfer(0, 12'h024, 0, rd, ps, pa, pu, cl); chk(2, "idiv rst", rd, 0);
    xfer(0, 12'h028, 0, rd, ps, pa, pu, cl); chk(2, "fdiv rst", rd, 0);
    xfer(0, 12'h020, 0, rd, ps, pa, pu, cl); chk(2, "irda rst", rd, 0);
    xfer(0, 12'h048, 0, rd, ps, pa, pu, cl); chk(2, "dma rst", rd, 0);
    xfer(0, 12'h038, 0, rd, ps, pa, pu, cl); chk(2, "mask rst", rd, 0);
    xfer(0, 12'h02C, 0, rd, ps, pa, pu, cl); chk(2, "line rst", rd, 0);
    xfer(0, 12'h030, 0, rd, ps, pa, pu, cl); chk(2, "ctrl rst", rd, 0);
    xfer(0, 12'h004, 0, rd, ps, pa, pu, cl); chk(2, "rxst rst", rd, 0);
    chk(2, "break rst", {31'b0, brk}, 0);

    // R1 R3 R7 R9 R11 vector walk
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i].wr, VEC[i].addr, VEC[i].wdata, rd, ps, pa, pu, cl);
      if (!VEC[i].wr) chk(int'(VEC[i].req), $sformatf("vec %0d", i), rd, VEC[i].exp);
    end

    // R4 R5: data read pops and latches error bits
    rx_data = 12'hA5C;
    xfer(0, 12'h000, 0, rd, ps, pa, pu, cl);
    chk(4, "data rd", rd, 32'hA5C);
    chk(4, "pop setup", {31'b0, ps}, 0);
    chk(4, "pop access", {31'b0, pa}, 1);
    rx_data = 12'h033;
    xfer(0, 12'h004, 0, rd, ps, pa, pu, cl); chk(5, "rxst latch", rd, 32'hA);
    chk(4, "no pop other", {31'b0, pa}, 0);
    // R6 clear on write
    xfer(1, 12'h004, 32'h0, rd, ps, pa, pu, cl);
    xfer(0, 12'h004, 0, rd, ps, pa, pu, cl); chk(6, "rxst clear", rd, 0);
    // R8 data write
    xfer(1, 12'h000, 32'h13C, rd, ps, pa, pu, cl);
    chk(8, "push", {31'b0, pu}, 1);
    chk(8, "tx data", {24'b0, tx_data}, 32'h3C);
    chk(4, "no pop on wr", {31'b0, pa}, 0);
    // R9 clear strobe
    @(negedge clk); psel = 1; pwr = 1; paddr = 12'h044; pwdata = 32'hF5A5;
    @(negedge clk); pen = 1;
    #1 begin chk(9, "clr strobe", {31'b0, irq_clr}, 1); chk(9, "clr mask", {21'b0, clr_mask}, 32'h5A5); end
    @(negedge clk); psel = 0; pen = 0; pwr = 0;
    // R7 masked status with partial mask
    xfer(1, 12'h038, 32'h00F, rd, ps, pa, pu, cl);
    xfer(0, 12'h040, 0, rd, ps, pa, pu, cl); chk(7, "masked", rd, 32'h3);
    // R12 break follows line bit 0
    xfer(1, 12'h02C, 32'h01, rd, ps, pa, pu, cl); chk(12, "break on", {31'b0, brk}, 1);
    xfer(1, 12'h02C, 32'h10, rd, ps, pa, pu, cl); chk(12, "break off", {31'b0, brk}, 0);
    // R10 identification bytes
    for (int k = 0; k < 8; k++) begin
      xfer(0, 12'hFE0 + 12'(k * 4), 0, rd, ps, pa, pu, cl);
      chk(10, $sformatf("id %0d", k), rd, {24'b0, id_exp[k]});
    end
    // R11 unmapped write discarded
    xfer(1, 12'h0FC, 32'hFFFF, rd, ps, pa, pu, cl);
    xfer(0, 12'h0FC, 0, rd, ps, pa, pu, cl); chk(11, "unmapped", rd, 0);
    xfer(0, 12'h024, 0, rd, ps, pa, pu, cl); chk(11, "idiv kept", rd, 32'hABCD);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule